// File: doc/BRIEF.md
# Multi-Channel PWM Output Router

This block is the last stage ahead of the A and B pins of a multi-channel PWM engine. Every channel presents three upstream waveforms (A, B and C) and the two outputs of its local edge generator. For each channel, the router picks what drives its A pin and what drives its B pin. Each pin has its own 4-bit mode select.

A mode either forwards the channel's own A or B unchanged (pass-through), or it picks a waveform from one of three places:
- the channel itself;
- the next channel or the one after it, counted around a ring of channels;
- the channel's edge generator.

Outputs are registered, so a change of mode or source reaches the pins on the next clock edge.

Fault blanking, GPIO gating and fine-delay (high-resolution) stages sit upstream. To silence a routed pin, the gating must be applied in the channel the waveform comes from. A per-channel flag reports routing while the fine-delay stage is enabled, which is a forbidden combination.

Top module: `pwm_out_router`

## Requirements
- R1: While rst_n is low, every pin_a, pin_b and cfg_err bit is 0 after the next clock edge, whatever the other inputs are.
- R2: Mode 0 (pass-through) drives pin_a[n] with ch_a[n] and pin_b[n] with ch_b[n].
- R3: Modes 1, 2 and 3 drive the pin with the channel's own A, B and C respectively.
- R4: Modes 4, 5 and 6 select A, B and C of channel (n+1) mod NUM_CH. Modes 7, 8 and 9 select A, B and C of channel (n+2) mod NUM_CH. For example, with five channels, channel 4 reads channel 0 and channel 1.
- R5: Mode 10 drives the pin with eg_a[n] and mode 11 drives it with eg_b[n].
- R6: Modes 12 to 15 are reserved and drive the pin low.
- R7: cfg_err[n] is 1 exactly when hires_en[n] was 1 and at least one of the two modes of channel n was nonzero at the previous clock edge.
- R8: Each output shows the inputs sampled at the preceding rising clock edge. Between edges it holds its value.
- R9: The A and B modes of a channel are independent. Each pin follows only its own mode field.

The mode of channel n for pin A is mode_a[4n+3:4n]. The mode for pin B is packed the same way in mode_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_a | input | NUM_CH | A waveform of each channel |
| ch_b | input | NUM_CH | B waveform of each channel |
| ch_c | input | NUM_CH | C waveform of each channel |
| eg_a | input | NUM_CH | First output of each channel's edge generator |
| eg_b | input | NUM_CH | Second output of each channel's edge generator |
| mode_a | input | NUM_CH*4 | Pin A mode, 4 bits per channel |
| mode_b | input | NUM_CH*4 | Pin B mode, 4 bits per channel |
| hires_en | input | NUM_CH | Fine-delay stage enabled, per channel |
| pin_a | output | NUM_CH | Routed A pin of each channel |
| pin_b | output | NUM_CH | Routed B pin of each channel |
| cfg_err | output | NUM_CH | Routing while fine delay is enabled |

## Verification
Every path from source to pin goes through a single register. A wrong selection therefore appears on the affected pin one clock after the offending mode is applied, as soon as the chosen and the correct source differ. A mistake in the ring wrap shows only on the last one or two channels, so the sweep sets every mode on every channel index. The data patterns make neighbouring sources differ often enough for such errors to appear. A bad error-flag term shows on cfg_err in the same cycle as the pins.

// File: rtl/rtr_pkg.sv
// Shared constants for the PWM output router: mode codes and source-vector sizes.
// Assumes modes are 4 bits wide and sources reach at most two ring hops away.
package rtr_pkg;
    localparam int MODE_W     = 4;
    localparam int NBR_HOPS   = 2;                     // furthest ring neighbour
    localparam int SIG_PER_CH = 3;                     // A, B, C per channel
    localparam int SRC_W      = SIG_PER_CH * (NBR_HOPS + 1);

    localparam logic [MODE_W-1:0] M_PASS = 4'd0;
    localparam logic [MODE_W-1:0] M_EG_A = 4'd10;
    localparam logic [MODE_W-1:0] M_EG_B = 4'd11;
endpackage

// File: rtl/rtr_src_mux.sv
// Combinational source selector for one pin.
// src is ordered {hop2 C,B,A, hop1 C,B,A, own C,B,A}; mode k (1..SRC_W) picks src[k-1].
// PASS_SEL gives the src bit forwarded in pass-through (0 = own A, 1 = own B).
module rtr_src_mux
    import rtr_pkg::*;
#(
    parameter int PASS_SEL = 0
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [SRC_W-1:0]  src,
    input  logic              eg_a,
    input  logic              eg_b,
    output logic              y
);
    // Decode the mode into one selected source; reserved codes give 0.
    always_comb begin
        y = 1'b0;
        if (mode == M_PASS) begin
            y = src[PASS_SEL];
        end else if (mode == M_EG_A) begin
            y = eg_a;
        end else if (mode == M_EG_B) begin
            y = eg_b;
        end else begin
            for (int k = 0; k < SRC_W; k++) begin
                if (mode == MODE_W'(k + 1)) y = src[k];
            end
        end
    end
endmodule

// File: rtl/rtr_slice.sv
// Routing slice for one channel: two independent selectors, the
// fine-delay interlock check and the output registers.
// Assumes the source vector was gathered in ring order by the parent.
module rtr_slice
    import rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src,
    input  logic              eg_a,
    input  logic              eg_b,
    input  logic [MODE_W-1:0] mode_a,
    input  logic [MODE_W-1:0] mode_b,
    input  logic              hires_en,
    output logic              pin_a,
    output logic              pin_b,
    output logic              cfg_err
);
    logic sel_a, sel_b, err_d;

    rtr_src_mux #(.PASS_SEL(0)) i_mux_a (
        .mode(mode_a), .src(src), .eg_a(eg_a), .eg_b(eg_b), .y(sel_a)
    );

    rtr_src_mux #(.PASS_SEL(1)) i_mux_b (
        .mode(mode_b), .src(src), .eg_a(eg_a), .eg_b(eg_b), .y(sel_b)
    );

    // Flag any non-pass-through routing while fine delay is enabled.
    always_comb begin
        err_d = hires_en && ((mode_a != M_PASS) || (mode_b != M_PASS));
    end

    // Register the pins and the flag so mode changes land glitch-free on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_a   <= 1'b0;
            pin_b   <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            pin_a   <= sel_a;
            pin_b   <= sel_b;
            cfg_err <= err_d;
        end
    end
endmodule

// File: rtl/pwm_out_router.sv
// Top of the PWM output router: gathers each channel's ring-relative sources
// and instantiates one routing slice per channel.
// Assumes NUM_CH >= 1; neighbour indices wrap modulo NUM_CH.
module pwm_out_router
    import rtr_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_a,
    input  logic [NUM_CH-1:0]        ch_b,
    input  logic [NUM_CH-1:0]        ch_c,
    input  logic [NUM_CH-1:0]        eg_a,
    input  logic [NUM_CH-1:0]        eg_b,
    input  logic [NUM_CH*MODE_W-1:0] mode_a,
    input  logic [NUM_CH*MODE_W-1:0] mode_b,
    input  logic [NUM_CH-1:0]        hires_en,
    output logic [NUM_CH-1:0]        pin_a,
    output logic [NUM_CH-1:0]        pin_b,
    output logic [NUM_CH-1:0]        cfg_err
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [SRC_W-1:0] src;

        for (genvar k = 0; k <= NBR_HOPS; k++) begin : g_hop
            localparam int SRC_CH = (n + k) % NUM_CH;
            assign src[SIG_PER_CH*k + 0] = ch_a[SRC_CH];
            assign src[SIG_PER_CH*k + 1] = ch_b[SRC_CH];
            assign src[SIG_PER_CH*k + 2] = ch_c[SRC_CH];
        end

        rtr_slice i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src),
            .eg_a     (eg_a[n]),
            .eg_b     (eg_b[n]),
            .mode_a   (mode_a[MODE_W*n +: MODE_W]),
            .mode_b   (mode_b[MODE_W*n +: MODE_W]),
            .hires_en (hires_en[n]),
            .pin_a    (pin_a[n]),
            .pin_b    (pin_b[n]),
            .cfg_err  (cfg_err[n])
        );
    end
endmodule

// File: rtl/pwm_out_router_chk.sv
// Assertion checker for pwm_out_router, attached by bind.
// Relates each pin to the sources and modes seen at the previous edge.
module pwm_out_router_chk
    import rtr_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        ch_a,
    input logic [NUM_CH-1:0]        ch_b,
    input logic [NUM_CH-1:0]        ch_c,
    input logic [NUM_CH-1:0]        eg_a,
    input logic [NUM_CH-1:0]        eg_b,
    input logic [NUM_CH*MODE_W-1:0] mode_a,
    input logic [NUM_CH*MODE_W-1:0] mode_b,
    input logic [NUM_CH-1:0]        hires_en,
    input logic [NUM_CH-1:0]        pin_a,
    input logic [NUM_CH-1:0]        pin_b,
    input logic [NUM_CH-1:0]        cfg_err
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        localparam int N1 = (n + 1) % NUM_CH;
        localparam int N2 = (n + 2) % NUM_CH;

        AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_a[MODE_W*n +: MODE_W]) == 4'd0) |-> pin_a[n] == $past(ch_a[n])); // R2
        AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_b[MODE_W*n +: MODE_W]) == 4'd0) |-> pin_b[n] == $past(ch_b[n])); // R2
        AST_OWN_C: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_a[MODE_W*n +: MODE_W]) == 4'd3) |-> pin_a[n] == $past(ch_c[n])); // R3
        AST_WRAP_HOP1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_a[MODE_W*n +: MODE_W]) == 4'd4) |-> pin_a[n] == $past(ch_a[N1])); // R4
        AST_WRAP_HOP2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_b[MODE_W*n +: MODE_W]) == 4'd9) |-> pin_b[n] == $past(ch_c[N2])); // R4
        AST_EDGE_GEN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_a[MODE_W*n +: MODE_W]) == 4'd11) |-> pin_a[n] == $past(eg_b[n])); // R5
        AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_b[MODE_W*n +: MODE_W]) >= 4'd12) |-> !pin_b[n]); // R6
        AST_HIRES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(hires_en[n])) |-> !cfg_err[n]); // R7
    end
endmodule

bind pwm_out_router pwm_out_router_chk #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_pwm_out_router.sv
// Self-checking bench: sweeps every mode pair over every channel index
// with pseudo-random source data, plus reset, latency and independence checks.
module test_pwm_out_router;
    localparam int NCH = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   ch_a = '0, ch_b = '0, ch_c = '0, eg_a = '0, eg_b = '0, hires_en = '0;
    logic [NCH*4-1:0] mode_a = '0, mode_b = '0;
    logic [NCH-1:0]   pin_a, pin_b, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    pwm_out_router #(.NUM_CH(NCH)) i_pwm_out_router (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
        .eg_a(eg_a), .eg_b(eg_b), .mode_a(mode_a), .mode_b(mode_b),
        .hires_en(hires_en), .pin_a(pin_a), .pin_b(pin_b), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, string what, int ch, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s ch%0d: actual %b expected %b", tag, what, ch, act, exp);
        end
    endtask

    function automatic logic [31:0] step_lfsr(logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // Expected pin value from the mode table in the requirements.
    function automatic logic exp_pin(int ch, int m, bit is_b);
        int hop, sig, s;
        if (m == 0) return is_b ? ch_b[ch] : ch_a[ch];
        if (m <= 9) begin
            hop = (m - 1) / 3;
            sig = (m - 1) % 3;
            s = (ch + hop) % NCH;
            return (sig == 0) ? ch_a[s] : (sig == 1) ? ch_b[s] : ch_c[s];
        end
        if (m == 10) return eg_a[ch];
        if (m == 11) return eg_b[ch];
        return 1'b0;
    endfunction

    function automatic string mode_tag(int m);
        if (m == 0) return "R2";
        if (m <= 3) return "R3";
        if (m <= 9) return "R4";
        if (m <= 11) return "R5";
        return "R6";
    endfunction

    task automatic random_data();
        lfsr = step_lfsr(lfsr); ch_a = lfsr[4:0];  ch_b = lfsr[9:5];  ch_c = lfsr[14:10];
        eg_a = lfsr[19:15]; eg_b = lfsr[24:20]; hires_en = lfsr[29:25];
        lfsr = step_lfsr(lfsr);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset clears all outputs even with active sources and modes.
        @(negedge clk);
        ch_a = '1; ch_b = '1; ch_c = '1; eg_a = '1; eg_b = '1; hires_en = '1;
        mode_a = {NCH{4'd1}}; mode_b = {NCH{4'd2}};
        @(posedge clk); @(negedge clk);
        for (int n = 0; n < NCH; n++) begin
            chk("R1", "pin_a in reset", n, pin_a[n], 1'b0);
            chk("R1", "pin_b in reset", n, pin_b[n], 1'b0);
            chk("R1", "cfg_err in reset", n, cfg_err[n], 1'b0);
        end
        rst_n = 1'b1;
        mode_a = '0; mode_b = '0; hires_en = '0;
        @(posedge clk); @(negedge clk);

        // R8: new input before an edge is not visible until that edge.
        ch_a = 5'b10101; ch_b = 5'b01010;
        @(posedge clk); @(negedge clk);
        ch_a = 5'b01010; ch_b = 5'b10101;
        #1;
        for (int n = 0; n < NCH; n++) chk("R8", "pin_a held between edges", n, pin_a[n], ~ch_a[n]);
        @(posedge clk); @(negedge clk);
        for (int n = 0; n < NCH; n++) chk("R8", "pin_a after edge", n, pin_a[n], ch_a[n]);

        // R9: own A on pin A, own C on pin B, with A and C opposite.
        mode_a = {NCH{4'd1}}; mode_b = {NCH{4'd3}};
        ch_a = 5'b11111; ch_c = 5'b00000; ch_b = 5'b11111;
        @(posedge clk); @(negedge clk);
        for (int n = 0; n < NCH; n++) begin
            chk("R9", "pin_a independent", n, pin_a[n], 1'b1);
            chk("R9", "pin_b independent", n, pin_b[n], 1'b0);
        end

        // Sweep: every A/B mode pair, rotated so each channel sees each mode.
        for (int ma = 0; ma < 16; ma++) begin
            for (int mb = 0; mb < 16; mb++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    random_data();
                    for (int n = 0; n < NCH; n++) begin
                        mode_a[4*n +: 4] = 4'((ma + n) % 16);
                        mode_b[4*n +: 4] = 4'((mb + 3 * n) % 16);
                    end
                    @(posedge clk); @(negedge clk);
                    for (int n = 0; n < NCH; n++) begin
                        int xa, xb;
                        xa = (ma + n) % 16;
                        xb = (mb + 3 * n) % 16;
                        chk(mode_tag(xa), "pin_a sweep", n, pin_a[n], exp_pin(n, xa, 1'b0));
                        chk(mode_tag(xb), "pin_b sweep", n, pin_b[n], exp_pin(n, xb, 1'b1));
                        chk("R7", "cfg_err sweep", n, cfg_err[n],
                            hires_en[n] && (xa != 0 || xb != 0));
                    end
                end
            end
        end
        finish_run();
    end
endmodule